// File: doc/BRIEF.md
# Halfword-to-Word Packing DMA Bridge with Gapped Host Layout

This block sits between a 16-bit bus master and a 32-bit shared-memory port. The master sees one continuous 64 KB region and moves data either in bursts of up to eight halfwords or as single halfword control accesses. The bridge packs burst halfwords in pairs into 32-bit memory writes. On reads it fetches one 32-bit word per pair and serves the second halfword of the pair from the captured word. The host sees the same region as a 128 KB window on a 128 KB boundary. In that window each 16-byte run of burst data is followed by a 16-byte hole, and each control halfword takes the low half of its own 32-bit slot.

The master side is a valid/ready stream. A beat transfers when `m_valid` and `m_ready` are both high at a clock edge. The master must hold the beat stable while `m_valid` is high and `m_ready` is low. `m_ready` is high only when the bridge is idle and DMA is enabled. Read data comes back on a second valid/ready stream. `s_rvalid` and `s_rdata` stay fixed until `s_rready` takes them, and no new beat is accepted before then. The memory port is also valid/ready. A request holds its address, data and byte enables until `mem_ready`. Read data returns in order on `mem_rvalid`, and only one request is outstanding at a time. Within a burst the master issues halfword addresses in ascending order and marks the final beat with `m_last`.

The window base comes from a pointer register. It is written with the buffer's physical address shifted left by three. An access outside the 64 KB master window raises a sticky error interrupt instead of reaching memory.

Top module: `gapped_dma_bridge`

## Requirements
- R1: In a burst, an even halfword address followed by the next odd address forms one pair. The pair is written as a single 32-bit memory write with byte enables 4'b1111. The even (first) halfword goes in bits [15:0] and the odd halfword in bits [31:16].
- R2: A burst halfword at master halfword address A maps to host byte offset (A[14:3] * 32) + (A[2:1] * 4). Bytes 16..31 of each 32-byte host block are never written by bursts.
- R3: A burst whose last beat is an even address writes that halfword alone: data {16'h0, half}, byte enables 4'b0011. A burst beat at an odd address with no pending even partner writes {half, 16'h0} with byte enables 4'b1100. No other byte enable pattern appears on a write.
- R4: A control (non-burst) access at halfword address A uses host byte offset A * 4. A control write drives {16'h0, half} with byte enables 4'b0011. A control read returns bits [15:0] of the memory word.
- R5: A burst read issues one memory read for the even beat of each pair. The odd beat that follows is answered from the captured word's bits [31:16] with no memory access. Eight beats cause four memory reads.
- R6: Writing `base_wdata` sets the window base to (`base_wdata` >> 3) with bits [16:0] forced to zero. `mem_addr` is base OR offset.
- R7: A beat with any of `m_addr[15]` set is outside the window. It sets `err_irq` from the next cycle and causes no memory request. If it is a read, it returns 16'h0000. `err_clr` clears `err_irq`, but a new error in the same cycle wins.
- R8: While `dma_en` is low, `m_ready` is low and no beat is accepted.
- R9: A memory request keeps `mem_addr`, `mem_wdata`, `mem_be` and `mem_we` stable until `mem_ready`. `m_ready` stays low while the request is pending.
- R10: Read data on `s_rdata` stays valid and stable until `s_rready` is high.
- R11: After reset `err_irq`, `mem_valid` and `s_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA enable; gates acceptance of master beats |
| base_we | input | 1 | Write strobe for the base pointer |
| base_wdata | input | 32 | Buffer physical address shifted left by 3 |
| err_clr | input | 1 | Clears the error interrupt |
| err_irq | output | 1 | Sticky out-of-window error interrupt |
| m_valid | input | 1 | Master beat valid |
| m_ready | output | 1 | Bridge accepts the beat |
| m_write | input | 1 | 1 = write beat, 0 = read beat |
| m_burst | input | 1 | 1 = burst beat, 0 = control halfword access |
| m_last | input | 1 | Final beat of a burst |
| m_addr | input | 16 | Master halfword address; bit 15 set is out of window |
| m_wdata | input | 16 | Write halfword |
| s_rvalid | output | 1 | Read halfword valid |
| s_rready | input | 1 | Master takes the read halfword |
| s_rdata | output | 16 | Read halfword |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Host byte address, word aligned |
| mem_wdata | output | 32 | Packed write word |
| mem_be | output | 4 | Byte enables |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read word |

## Verification
The hardest case to reach from the ports is a write burst cut short on an even address. It is the only path that flushes a half-filled word. A closely related case is an odd beat that arrives with no partner stored. The bench reaches the first with a three-beat burst that raises `m_last` on its third beat. It reaches the second with a one-beat burst at an odd address. It then checks the byte enables and half placement of every write the memory model logged. A second hard case is memory back-pressure in the middle of a request. The bench holds `mem_ready` low for several cycles and checks that the request stays pending, that nothing reaches memory and that the master is stalled.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMW,
    ST_MEMR,
    ST_WAITR,
    ST_RESP
  } gdb_state_e;
endpackage

// File: rtl/gdb_xlate.sv
// Master halfword address -> host byte offset inside the 128 KB window.
module gdb_xlate #(
  parameter int WIN_W = 15,
  parameter int CH_B  = 3,
  parameter int OFF_W = WIN_W + 2
) (
  input  logic [WIN_W-1:0] hw_addr,
  input  logic             burst,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] off_burst;
  logic [OFF_W-1:0] off_ctrl;

  generate
    if (CH_B > 1) begin : g_multi
      // chunk index doubled (hole after each chunk), word within chunk
      assign off_burst = {hw_addr[WIN_W-1:CH_B], 1'b0, hw_addr[CH_B-1:1], 2'b00};
    end else begin : g_single
      assign off_burst = {hw_addr[WIN_W-1:1], 1'b0, 2'b00};
    end
  endgenerate

  // control halfword: one 32-bit slot per halfword
  assign off_ctrl = {hw_addr, 2'b00};
  assign off      = burst ? off_burst : off_ctrl;
endmodule

// File: rtl/gdb_pack.sv
// Pairs burst halfwords into 32-bit words; flushes lone halves.
module gdb_pack #(
  parameter int HW    = 16,
  parameter int TAG_W = 14,
  parameter int BE_W  = (2 * HW) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              burst,
  input  logic              last,
  input  logic              odd,
  input  logic [TAG_W-1:0]  tag,
  input  logic [HW-1:0]     wdata,
  output logic              issue,
  output logic [2*HW-1:0]   word,
  output logic [BE_W-1:0]   be
);
  localparam logic [BE_W-1:0] BE_LO   = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [BE_W-1:0] BE_HI   = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

  logic             pend_q;
  logic [HW-1:0]    held_q;
  logic [TAG_W-1:0] ptag_q;

  always_comb begin
    issue = 1'b1;
    word  = {{HW{1'b0}}, wdata};
    be    = BE_LO;
    if (burst) begin
      if (!odd) begin
        issue = last;
      end else if (pend_q && ptag_q == tag) begin
        word = {wdata, held_q};
        be   = BE_FULL;
      end else begin
        word = {wdata, {HW{1'b0}}};
        be   = BE_HI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= '0;
      ptag_q <= '0;
    end else if (beat) begin
      pend_q <= burst && !odd && !last;
      held_q <= wdata;
      ptag_q <= tag;
    end
  end

  // a stored even half must be followed by its odd partner
  assert_pair_partner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && beat) |-> (burst && odd && tag == ptag_q));
endmodule

// File: rtl/gapped_dma_bridge.sv
module gapped_dma_bridge #(
  parameter int HW      = 16,
  parameter int MA_W    = 16,
  parameter int WIN_W   = 15,
  parameter int CH_B    = 3,
  parameter int HA_W    = 32,
  parameter int BASE_SH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              base_we,
  input  logic [HA_W-1:0]   base_wdata,
  input  logic              err_clr,
  output logic              err_irq,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic              m_write,
  input  logic              m_burst,
  input  logic              m_last,
  input  logic [MA_W-1:0]   m_addr,
  input  logic [HW-1:0]     m_wdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [HW-1:0]     s_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [HA_W-1:0]   mem_addr,
  output logic [2*HW-1:0]   mem_wdata,
  output logic [(2*HW)/8-1:0] mem_be,
  input  logic              mem_rvalid,
  input  logic [2*HW-1:0]   mem_rdata
);
  import gdb_pkg::*;

  localparam int OFF_W = WIN_W + 2;
  localparam int TAG_W = WIN_W - 1;
  localparam int BE_W  = (2 * HW) / 8;
  localparam logic [HA_W-1:0] OFF_MASK = {{(HA_W-OFF_W){1'b0}}, {OFF_W{1'b1}}};

  gdb_state_e        st_q;
  logic [HA_W-1:0]   base_q;
  logic [HA_W-1:0]   req_addr_q;
  logic [2*HW-1:0]   req_data_q;
  logic [BE_W-1:0]   req_be_q;
  logic              req_we_q;
  logic [HW-1:0]     rsp_q;
  logic              sel_hi_q;
  logic              rd_burst_q;
  logic [TAG_W-1:0]  rd_tag_q;
  logic              cache_v_q;
  logic [TAG_W-1:0]  cache_tag_q;
  logic [2*HW-1:0]   cache_word_q;
  logic              err_q;

  logic              in_win;
  logic              acc;
  logic              hit;
  logic [TAG_W-1:0]  pair_tag;
  logic [OFF_W-1:0]  off;
  logic [HA_W-1:0]   host_a;
  logic              pk_issue;
  logic [2*HW-1:0]   pk_word;
  logic [BE_W-1:0]   pk_be;
  logic [HA_W-1:0]   base_shifted;

  assign in_win   = (m_addr[MA_W-1:WIN_W] == '0);
  assign m_ready  = dma_en && (st_q == ST_IDLE);
  assign acc      = m_valid && m_ready;
  assign pair_tag = m_addr[WIN_W-1:1];
  assign hit      = cache_v_q && m_burst && m_addr[0] && (cache_tag_q == pair_tag);
  assign host_a   = base_q | {{(HA_W-OFF_W){1'b0}}, off};
  assign base_shifted = base_wdata >> BASE_SH;

  gdb_xlate #(.WIN_W(WIN_W), .CH_B(CH_B), .OFF_W(OFF_W)) u_xlate (
    .hw_addr (m_addr[WIN_W-1:0]),
    .burst   (m_burst),
    .off     (off)
  );

  gdb_pack #(.HW(HW), .TAG_W(TAG_W), .BE_W(BE_W)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (acc && in_win && m_write),
    .burst (m_burst),
    .last  (m_last),
    .odd   (m_addr[0]),
    .tag   (pair_tag),
    .wdata (m_wdata),
    .issue (pk_issue),
    .word  (pk_word),
    .be    (pk_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      base_q       <= '0;
      req_addr_q   <= '0;
      req_data_q   <= '0;
      req_be_q     <= '0;
      req_we_q     <= 1'b0;
      rsp_q        <= '0;
      sel_hi_q     <= 1'b0;
      rd_burst_q   <= 1'b0;
      rd_tag_q     <= '0;
      cache_v_q    <= 1'b0;
      cache_tag_q  <= '0;
      cache_word_q <= '0;
      err_q        <= 1'b0;
    end else begin
      if (acc && !in_win)  err_q <= 1'b1;
      else if (err_clr)    err_q <= 1'b0;

      case (st_q)
        ST_IDLE: if (acc) begin
          if (!in_win) begin
            if (!m_write) begin
              rsp_q <= '0;
              st_q  <= ST_RESP;
            end
          end else if (m_write) begin
            cache_v_q <= 1'b0;
            if (pk_issue) begin
              req_addr_q <= host_a;
              req_data_q <= pk_word;
              req_be_q   <= pk_be;
              req_we_q   <= 1'b1;
              st_q       <= ST_MEMW;
            end
          end else if (hit) begin
            rsp_q <= cache_word_q[2*HW-1:HW];
            st_q  <= ST_RESP;
          end else begin
            req_addr_q <= host_a;
            req_we_q   <= 1'b0;
            req_be_q   <= '1;
            sel_hi_q   <= m_burst && m_addr[0];
            rd_burst_q <= m_burst;
            rd_tag_q   <= pair_tag;
            st_q       <= ST_MEMR;
          end
        end
        ST_MEMW:  if (mem_ready) st_q <= ST_IDLE;
        ST_MEMR:  if (mem_ready) st_q <= ST_WAITR;
        ST_WAITR: if (mem_rvalid) begin
          cache_v_q    <= rd_burst_q;
          cache_tag_q  <= rd_tag_q;
          cache_word_q <= mem_rdata;
          rsp_q        <= sel_hi_q ? mem_rdata[2*HW-1:HW] : mem_rdata[HW-1:0];
          st_q         <= ST_RESP;
        end
        ST_RESP:  if (s_rready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase

      if (base_we) begin
        base_q    <= base_shifted & ~OFF_MASK;
        cache_v_q <= 1'b0;
      end
    end
  end

  assign mem_valid = (st_q == ST_MEMW) || (st_q == ST_MEMR);
  assign mem_we    = req_we_q;
  assign mem_addr  = req_addr_q;
  assign mem_wdata = req_data_q;
  assign mem_be    = req_be_q;
  assign s_rvalid  = (st_q == ST_RESP);
  assign s_rdata   = rsp_q;
  assign err_irq   = err_q;

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
     $stable(mem_wdata) && $stable(mem_be) && $stable(mem_we)));

  assert_stall_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !m_ready);

  assert_be_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_be == 4'b1111 || mem_be == 4'b0011 || mem_be == 4'b1100));

  assert_oow_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !in_win) |=> (err_irq && !mem_valid));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

  assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && $past(!dma_en) && $past(!mem_valid) && $past(!s_rvalid)) |-> !mem_valid);
endmodule

// File: tb/gapped_dma_bridge_tb.sv
module gapped_dma_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        err_clr = 1'b0;
  logic        err_irq;
  logic        m_valid = 1'b0;
  logic        m_ready;
  logic        m_write = 1'b0;
  logic        m_burst = 1'b0;
  logic        m_last = 1'b0;
  logic [15:0] m_addr = '0;
  logic [15:0] m_wdata = '0;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic [15:0] s_rdata;
  logic        mem_valid;
  logic        mem_rdy = 1'b1;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] BASE = 32'h0010_0000;

  always #4 clk = ~clk;

  gapped_dma_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .base_we(base_we),
    .base_wdata(base_wdata), .err_clr(err_clr), .err_irq(err_irq),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_burst(m_burst), .m_last(m_last), .m_addr(m_addr), .m_wdata(m_wdata),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_rdy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: logs writes, answers reads one cycle after acceptance
  int          wcnt = 0;
  int          rcnt = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  logic [3:0]  log_b [64];

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5A5, a[15:0]};
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_rdy) begin
      if (mem_we) begin
        log_a[wcnt % 64] = mem_addr;
        log_d[wcnt % 64] = mem_wdata;
        log_b[wcnt % 64] = mem_be;
        wcnt = wcnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rdfn(mem_addr);
        rcnt = rcnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic wr, input logic bu, input logic la,
                      input logic [15:0] a, input logic [15:0] d);
    m_valid = 1'b1; m_write = wr; m_burst = bu; m_last = la;
    m_addr = a; m_wdata = d;
    while (!m_ready) @(negedge clk);
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  task automatic rd_beat(input logic bu, input logic la, input logic [15:0] a,
                         output logic [15:0] d);
    beat(1'b0, bu, la, a, 16'h0);
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_wr(input string req, input int idx, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] b);
    check({req, " addr"}, log_a[idx % 64], a);
    check({req, " data"}, log_d[idx % 64], d);
    check({req, " be"}, {28'h0, log_b[idx % 64]}, {28'h0, b});
  endtask

  task automatic t_reset();
    check("R11 err_irq", {31'h0, err_irq}, 32'h0);
    check("R11 mem_valid", {31'h0, mem_valid}, 32'h0);
    check("R11 s_rvalid", {31'h0, s_rvalid}, 32'h0);
    check("R8 m_ready while disabled", {31'h0, m_ready}, 32'h0);
  endtask

  task automatic t_base();
    int w0 = wcnt;
    base_we = 1'b1; base_wdata = (BASE << 3) | 32'h0000_0FF8;
    @(negedge clk); base_we = 1'b0;
    beat(1'b1, 1'b0, 1'b0, 16'h0000, 16'h1234);
    settle();
    check("R6 one write", wcnt - w0, 1);
    chk_wr("R6 masked base", w0, BASE, 32'h0000_1234, 4'b0011);
  endtask

  task automatic t_burst_full();
    int w0 = wcnt;
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b1, i == 7, 16'h0010 + 16'(i), 16'h1000 + 16'(i));
    settle();
    check("R1 four writes", wcnt - w0, 4);
    for (int k = 0; k < 4; k++)
      chk_wr("R1 R2 pair", w0 + k, BASE + 32'h40 + 32'(4 * k),
             {16'h1001 + 16'(2 * k), 16'h1000 + 16'(2 * k)}, 4'b1111);
    w0 = wcnt;
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b1, i == 7, 16'h0018 + 16'(i), 16'h3000 + 16'(i));
    settle();
    check("R2 next chunk writes", wcnt - w0, 4);
    chk_wr("R2 gap skipped", w0, BASE + 32'h60, 32'h3001_3000, 4'b1111);
    chk_wr("R2 chunk end", w0 + 3, BASE + 32'h6C, 32'h3007_3006, 4'b1111);
  endtask

  task automatic t_burst_short();
    int w0 = wcnt;
    for (int i = 0; i < 3; i++) beat(1'b1, 1'b1, i == 2, 16'h0020 + 16'(i), 16'h2000 + 16'(i));
    settle();
    check("R3 cut short writes", wcnt - w0, 2);
    chk_wr("R3 full pair", w0, BASE + 32'h80, 32'h2001_2000, 4'b1111);
    chk_wr("R3 lone even flush", w0 + 1, BASE + 32'h84, 32'h0000_2002, 4'b0011);
    w0 = wcnt;
    beat(1'b1, 1'b1, 1'b1, 16'h0031, 16'h5A5A);
    settle();
    check("R3 lone odd count", wcnt - w0, 1);
    chk_wr("R3 lone odd", w0, BASE + 32'hC0, 32'h5A5A_0000, 4'b1100);
  endtask

  task automatic t_ctrl();
    int w0 = wcnt;
    int r0 = rcnt;
    logic [15:0] d;
    beat(1'b1, 1'b0, 1'b0, 16'h0005, 16'hBEEF);
    settle();
    chk_wr("R4 ctrl write", w0, BASE + 32'h14, 32'h0000_BEEF, 4'b0011);
    rd_beat(1'b0, 1'b0, 16'h0005, d);
    check("R4 ctrl read data", {16'h0, d}, 32'h0000_0014);
    check("R4 ctrl read count", rcnt - r0, 1);
  endtask

  task automatic t_burst_read();
    int r0 = rcnt;
    logic [15:0] d;
    logic [31:0] wa;
    for (int i = 0; i < 8; i++) begin
      rd_beat(1'b1, i == 7, 16'h0010 + 16'(i), d);
      wa = BASE + 32'h40 + 32'(4 * (i / 2));
      check("R5 burst read half", {16'h0, d},
            {16'h0, (i % 2 == 1) ? (wa[15:0] ^ 16'hA5A5) : wa[15:0]});
    end
    check("R5 four memory reads", rcnt - r0, 4);
  endtask

  task automatic t_oow();
    int w0 = wcnt;
    int r0 = rcnt;
    logic [15:0] d;
    beat(1'b1, 1'b0, 1'b0, 16'h8000, 16'hDEAD);
    settle();
    check("R7 write suppressed", wcnt - w0, 0);
    check("R7 err set", {31'h0, err_irq}, 32'h1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check("R7 err cleared", {31'h0, err_irq}, 32'h0);
    rd_beat(1'b1, 1'b1, 16'hC003, d);
    check("R7 oow read zero", {16'h0, d}, 32'h0);
    check("R7 no memory read", rcnt - r0, 0);
    check("R7 err on read", {31'h0, err_irq}, 32'h1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_disable();
    int w0 = wcnt;
    bit seen = 0;
    dma_en = 1'b0;
    m_valid = 1'b1; m_write = 1'b1; m_burst = 1'b0; m_last = 1'b0;
    m_addr = 16'h0007; m_wdata = 16'h7777;
    repeat (5) begin
      @(negedge clk);
      if (m_ready) seen = 1;
    end
    check("R8 no ready when off", {31'h0, seen}, 32'h0);
    check("R8 nothing written", wcnt - w0, 0);
    dma_en = 1'b1;
    while (!m_ready) @(negedge clk);
    @(negedge clk); m_valid = 1'b0;
    settle();
    chk_wr("R8 accepted after enable", w0, BASE + 32'h1C, 32'h0000_7777, 4'b0011);
  endtask

  task automatic t_backpressure();
    int w0 = wcnt;
    logic [15:0] d;
    mem_rdy = 1'b0;
    beat(1'b1, 1'b0, 1'b0, 16'h0009, 16'h9999);
    repeat (5) @(negedge clk);
    check("R9 request pending", {31'h0, mem_valid}, 32'h1);
    check("R9 master stalled", {31'h0, m_ready}, 32'h0);
    check("R9 not yet written", wcnt - w0, 0);
    check("R9 addr held", mem_addr, BASE + 32'h24);
    mem_rdy = 1'b1;
    settle();
    chk_wr("R9 write done", w0, BASE + 32'h24, 32'h0000_9999, 4'b0011);
    s_rready = 1'b0;
    beat(1'b0, 1'b0, 1'b0, 16'h0009, 16'h0);
    while (!s_rvalid) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R10 rvalid held", {31'h0, s_rvalid}, 32'h1);
    check("R10 rdata held", {16'h0, s_rdata}, 32'h0000_0024);
    s_rready = 1'b1;
    @(negedge clk);
    check("R10 released", {31'h0, s_rvalid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    dma_en = 1'b1;
    @(negedge clk);
    t_base();
    t_burst_full();
    t_burst_short();
    t_ctrl();
    t_burst_read();
    t_oow();
    t_disable();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule